// File: doc/BRIEF.md
# LPC Host Memory Cycle Engine

This block is the host side of a Low Pin Count bus, restricted to memory transactions. A requester hands it one read or write of 1, 2 or 4 bytes. The engine runs the transfer on the 4-bit multiplexed LAD bus, framed by an active-low LFRAME strobe, and then returns one response. The request address selects one of three cycle flavours: a TPM cycle for a fixed 4 KB window, a firmware memory cycle for a parameterised code region, and a standard memory cycle for everything else, including all addresses below 16 MB.

Each bus transfer moves exactly one byte. A wider request becomes a run of single-byte transfers at ascending addresses, and the read bytes are merged before the response is raised. After every turnaround the engine samples the target's SYNC nibble, and it follows wait codes up to a limit. If no target answers, or a target waits too long, the engine frames an abort and completes the request with all-ones data.

Top module: `lpc_mem_host`

## Requirements
- R1: An address from 0xFED40000 through 0xFED40FFF, inclusive, is sent with START nibble 0101. Its header is the standard one, and this window takes priority over every other rule. 0xFED41000 is not in the window.
- R2: An address inside [FW_LO, FW_HI] (default 0xFF000000 to 0xFFFFFFFF) uses START 1101 for a read and 1110 for a write. The header is nine nibbles: an IDSEL nibble of 0000, then address bits 27:0 as seven nibbles with the most significant first, then an MSIZE nibble of 0000.
- R3: Any other address uses START 0000. The header is a direction nibble (0100 for a read, 0110 for a write), then the 32-bit address as eight nibbles with the most significant first.
- R4: Outside an abort, lfrmN is low only on the single START clock of each byte transfer, and ladOe is high whenever lfrmN is low.
- R5: reqSize 0, 1 and 2 request 1, 2 and 4 bytes. Byte i goes out at address reqAddr+i. A write sends reqWdata[8i+7:8i]. A read returns that byte in rspRdata[8i+7:8i], and unrequested bytes read as zero.
- R6: Data bytes cross LAD low nibble first, in both directions.
- R7: After its last driven nibble, the host drives 1111 for one clock, then releases LAD (ladOe low) for the whole target phase and for the two clocks that follow it.
- R8: SYNC 0101 (short wait) and 0110 (long wait) extend the cycle, and 0000 ends it. When WAIT_LIMIT wait clocks occur in one SYNC phase, the engine aborts.
- R9: A SYNC clock that carries no valid code counts toward a timeout. When NOSYNC_LIMIT such clocks occur in a row, the engine aborts. A wait code resets the count.
- R10: In a firmware cycle, 1010 is not a valid code and is treated like no response.
- R11: In a standard or TPM cycle, a 1010 SYNC aborts the transfer at once.
- R12: An abort holds lfrmN low with LAD driven to 1111 for ABORT_CLKS (default 4) clocks. The remaining bytes are skipped, and the response carries rspAbort=1 with rspRdata all ones.
- R13: Out of reset, lfrmN is high, ladOe is low, reqReady is high and rspValid is low. reqReady is high only while idle, and rspValid is a one-clock pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the first byte |
| reqSize | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| reqWdata | input | 32 | Write bytes, byte i in bits 8i+7:8i |
| reqReady | output | 1 | Engine idle |
| rspValid | output | 1 | One-clock completion pulse |
| rspAbort | output | 1 | Completion came from an abort |
| rspRdata | output | 32 | Merged read bytes, or all ones on abort |
| ladOut | output | 4 | Nibble the host drives on LAD |
| ladOe | output | 1 | Host LAD driver enable |
| ladIn | input | 4 | Nibble sampled from LAD |
| lfrmN | output | 1 | Active-low frame strobe |

## Verification
A reactive target model decodes each frame and answers with a configurable sequence of junk, short-wait, long-wait, ready and data nibbles. Reads and writes of each width are aimed at each address class, with addresses chosen to straddle the TPM window edge and a byte carry. These show whether the class, nibble order and byte merging are right. The wait and junk counts are set one below and exactly at each limit. An error code is sent in both a firmware and a standard cycle. A wait is placed between two junk runs to show whether it clears the timeout count. A silent target during a 4-byte read shows whether later bytes are skipped and the abort frame has the right length.

// File: rtl/lpc_mem_pkg.sv
package lpc_mem_pkg;
  localparam int IDX_W = 4;
  localparam logic [31:0] TPM_LO = 32'hFED4_0000;
  localparam logic [31:0] TPM_HI = 32'hFED4_0FFF;

  localparam logic [3:0] START_STD  = 4'b0000;
  localparam logic [3:0] START_TPM  = 4'b0101;
  localparam logic [3:0] START_FWRD = 4'b1101;
  localparam logic [3:0] START_FWWR = 4'b1110;
  localparam logic [3:0] DIR_RD     = 4'b0100;
  localparam logic [3:0] DIR_WR     = 4'b0110;

  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;

  typedef enum logic [1:0] {KIND_STD, KIND_TPM, KIND_FW} cycKind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HDR, ST_WDATA, ST_TAR1, ST_TAR2,
    ST_SYNC, ST_RDATA, ST_TARB, ST_ABORT, ST_DONE
  } phase_e;

  typedef struct packed {
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             load;
    logic             nextByte;
    logic             capLo;
    logic             capHi;
    logic             fillOnes;
  } dpCtl_t;
endpackage

// File: rtl/lpc_mem_dp.sv
module lpc_mem_dp
  import lpc_mem_pkg::*;
#(
  parameter logic [31:0] FW_LO = 32'hFF00_0000,
  parameter logic [31:0] FW_HI = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  logic [3:0]  ladIn,
  output cycKind_e    kind,
  output logic        isWrite,
  output logic        lastByte,
  output logic [3:0]  ladOut,
  output logic [31:0] rdata
);
  logic [31:0] baseAddr, wdataR;
  logic [1:0]  sizeR, byteIdx, lastIdx;
  logic [31:0] curAddr;
  logic [7:0][3:0] addrNib;
  logic [7:0]  wByte;

  assign curAddr  = baseAddr + 32'(byteIdx);
  assign addrNib  = curAddr;
  assign wByte    = wdataR[{byteIdx, 3'b000} +: 8];
  assign lastIdx  = (sizeR == 2'd0) ? 2'd0 : (sizeR == 2'd1) ? 2'd1 : 2'd3;
  assign lastByte = (byteIdx == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0; wdataR <= '0; sizeR <= '0; byteIdx <= '0;
      kind <= KIND_STD; isWrite <= 1'b0; rdata <= '0;
    end else begin
      if (ctl.load) begin
        baseAddr <= reqAddr; wdataR <= reqWdata; sizeR <= reqSize;
        isWrite  <= reqWrite; byteIdx <= '0; rdata <= '0;
        if (reqAddr >= TPM_LO && reqAddr <= TPM_HI)     kind <= KIND_TPM;
        else if (reqAddr >= FW_LO && reqAddr <= FW_HI)  kind <= KIND_FW;
        else                                            kind <= KIND_STD;
      end
      if (ctl.nextByte) byteIdx <= byteIdx + 2'd1;
      if (ctl.capLo)    rdata[{byteIdx, 3'b000} +: 4] <= ladIn;
      if (ctl.capHi)    rdata[{byteIdx, 3'b100} +: 4] <= ladIn;
      if (ctl.fillOnes) rdata <= '1;
    end
  end

  always_comb begin
    ladOut = 4'hF;
    unique case (ctl.phase)
      ST_START: begin
        if (kind == KIND_TPM)     ladOut = START_TPM;
        else if (kind == KIND_FW) ladOut = isWrite ? START_FWWR : START_FWRD;
        else                      ladOut = START_STD;
      end
      ST_HDR: begin
        if (kind == KIND_FW) begin
          if (ctl.idx == '0 || ctl.idx == IDX_W'(8)) ladOut = 4'h0;
          else ladOut = addrNib[3'(IDX_W'(7) - ctl.idx)];
        end else begin
          if (ctl.idx == '0) ladOut = isWrite ? DIR_WR : DIR_RD;
          else ladOut = addrNib[3'(IDX_W'(8) - ctl.idx)];
        end
      end
      ST_WDATA: ladOut = (ctl.idx == '0) ? wByte[3:0] : wByte[7:4];
      default:  ladOut = 4'hF;
    endcase
  end
endmodule

// File: rtl/lpc_mem_ctrl.sv
module lpc_mem_ctrl
  import lpc_mem_pkg::*;
#(
  parameter int WAIT_LIMIT   = 16,
  parameter int NOSYNC_LIMIT = 4,
  parameter int ABORT_CLKS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] ladIn,
  input  cycKind_e   kind,
  input  logic       isWrite,
  input  logic       lastByte,
  output dpCtl_t     ctl,
  output logic       lfrmN,
  output logic       ladOe,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspAbort
);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam int NS_W   = $clog2(NOSYNC_LIMIT + 1);
  localparam int HDR_LAST = 8;

  phase_e phase, phaseNx;
  logic [IDX_W-1:0]  idx, idxNx;
  logic [WAIT_W-1:0] waitCnt, waitNx;
  logic [NS_W-1:0]   noSyncCnt, noSyncNx;
  logic aborted, abortedNx, goAbort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE; idx <= '0; waitCnt <= '0; noSyncCnt <= '0; aborted <= 1'b0;
    end else begin
      phase <= phaseNx; idx <= idxNx; waitCnt <= waitNx;
      noSyncCnt <= noSyncNx; aborted <= abortedNx;
    end
  end

  always_comb begin
    phaseNx = phase; idxNx = idx; waitNx = waitCnt; noSyncNx = noSyncCnt;
    abortedNx = aborted; goAbort = 1'b0;
    ctl = '0; ctl.phase = phase; ctl.idx = idx;
    unique case (phase)
      ST_IDLE:  if (reqValid) begin ctl.load = 1'b1; abortedNx = 1'b0; phaseNx = ST_START; end
      ST_START: begin phaseNx = ST_HDR; idxNx = '0; end
      ST_HDR: begin
        if (idx == IDX_W'(HDR_LAST)) begin idxNx = '0; phaseNx = isWrite ? ST_WDATA : ST_TAR1; end
        else idxNx = idx + 1'b1;
      end
      ST_WDATA: begin
        if (idx == IDX_W'(1)) begin idxNx = '0; phaseNx = ST_TAR1; end
        else idxNx = idx + 1'b1;
      end
      ST_TAR1:  phaseNx = ST_TAR2;
      ST_TAR2:  begin phaseNx = ST_SYNC; waitNx = '0; noSyncNx = '0; end
      ST_SYNC: begin
        if (ladIn == SYNC_READY) begin
          idxNx = '0; phaseNx = isWrite ? ST_TARB : ST_RDATA;
        end else if (ladIn == SYNC_SHORT || ladIn == SYNC_LONG) begin
          noSyncNx = '0;
          if (waitCnt == WAIT_W'(WAIT_LIMIT - 1)) goAbort = 1'b1;
          else waitNx = waitCnt + 1'b1;
        end else if (ladIn == SYNC_ERR && kind != KIND_FW) begin
          goAbort = 1'b1;
        end else begin
          if (noSyncCnt == NS_W'(NOSYNC_LIMIT - 1)) goAbort = 1'b1;
          else noSyncNx = noSyncCnt + 1'b1;
        end
        if (goAbort) begin phaseNx = ST_ABORT; idxNx = '0; abortedNx = 1'b1; end
      end
      ST_RDATA: begin
        ctl.capLo = (idx == '0);
        ctl.capHi = (idx == IDX_W'(1));
        if (idx == IDX_W'(1)) begin idxNx = '0; phaseNx = ST_TARB; end
        else idxNx = idx + 1'b1;
      end
      ST_TARB: begin
        if (idx == IDX_W'(1)) begin
          idxNx = '0;
          if (lastByte) phaseNx = ST_DONE;
          else begin ctl.nextByte = 1'b1; phaseNx = ST_START; end
        end else idxNx = idx + 1'b1;
      end
      ST_ABORT: begin
        if (idx == IDX_W'(ABORT_CLKS - 1)) begin ctl.fillOnes = 1'b1; phaseNx = ST_DONE; end
        else idxNx = idx + 1'b1;
      end
      ST_DONE:  phaseNx = ST_IDLE;
      default:  phaseNx = ST_IDLE;
    endcase
  end

  assign lfrmN    = !(phase == ST_START || phase == ST_ABORT);
  assign ladOe    = (phase == ST_START) || (phase == ST_HDR) || (phase == ST_WDATA) ||
                    (phase == ST_TAR1) || (phase == ST_ABORT);
  assign reqReady = (phase == ST_IDLE);
  assign rspValid = (phase == ST_DONE);
  assign rspAbort = (phase == ST_DONE) && aborted;
endmodule

// File: rtl/lpc_mem_host.sv
module lpc_mem_host
  import lpc_mem_pkg::*;
#(
  parameter logic [31:0] FW_LO        = 32'hFF00_0000,
  parameter logic [31:0] FW_HI        = 32'hFFFF_FFFF,
  parameter int          WAIT_LIMIT   = 16,
  parameter int          NOSYNC_LIMIT = 4,
  parameter int          ABORT_CLKS   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        reqReady,
  output logic        rspValid,
  output logic        rspAbort,
  output logic [31:0] rspRdata,
  output logic [3:0]  ladOut,
  output logic        ladOe,
  input  logic [3:0]  ladIn,
  output logic        lfrmN
);
  dpCtl_t   ctl;
  cycKind_e kind;
  logic     isWrite, lastByte;

  lpc_mem_ctrl #(.WAIT_LIMIT(WAIT_LIMIT), .NOSYNC_LIMIT(NOSYNC_LIMIT), .ABORT_CLKS(ABORT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ladIn(ladIn), .kind(kind),
    .isWrite(isWrite), .lastByte(lastByte), .ctl(ctl), .lfrmN(lfrmN), .ladOe(ladOe),
    .reqReady(reqReady), .rspValid(rspValid), .rspAbort(rspAbort)
  );

  lpc_mem_dp #(.FW_LO(FW_LO), .FW_HI(FW_HI)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .ladIn(ladIn), .kind(kind),
    .isWrite(isWrite), .lastByte(lastByte), .ladOut(ladOut), .rdata(rspRdata)
  );
endmodule

// File: rtl/lpc_mem_host_chk.sv
module lpc_mem_host_chk #(
  parameter int ABORT_CLKS = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspAbort,
  input logic [31:0] rspRdata,
  input logic [3:0]  ladOut,
  input logic        ladOe,
  input logic        lfrmN
);
  logic       abortFrame;
  logic [7:0] abortRun;
  assign abortFrame = !lfrmN && ladOe && (ladOut == 4'hF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) abortRun <= '0;
    else if (abortFrame) abortRun <= abortRun + 8'd1;
    else abortRun <= '0;
  end

  p_start_one_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!lfrmN && ladOut != 4'hF) |=> lfrmN);
  p_frame_driven_r4: assert property (@(posedge clk) disable iff (!rstN)
    !lfrmN |-> ladOe);
  p_release_after_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ladOe) |-> ($past(ladOut) == 4'hF));
  p_abort_len_r12: assert property (@(posedge clk) disable iff (!rstN)
    (abortRun != 8'd0 && !abortFrame) |-> (abortRun >= 8'(ABORT_CLKS)));
  p_abort_ones_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> (rspValid && rspRdata == 32'hFFFF_FFFF));
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

bind lpc_mem_host lpc_mem_host_chk #(.ABORT_CLKS(ABORT_CLKS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspAbort(rspAbort), .rspRdata(rspRdata),
  .ladOut(ladOut), .ladOe(ladOe), .lfrmN(lfrmN)
);

// File: tb/lpc_mem_host_tb.sv
module lpc_mem_host_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0] reqSize = '0;
  logic reqReady, rspValid, rspAbort, ladOe, lfrmN;
  logic [31:0] rspRdata;
  logic [3:0] ladOut;
  logic [3:0] ladIn = 4'hF;

  int vecs = 0, fails = 0;
  int nJunk = 0, nShort = 0, nLong = 0, nJunk2 = 0;
  logic [3:0] junkNib = 4'hF;
  bit noReady = 0;
  int recN = 0, frameErr = 0, contention = 0, abortLen = 0, abortRun = 0;
  logic [3:0] recStart[4], recHdr0[4], recHdr8[4], recTar[4];
  logic [31:0] recAddr[4];
  logic [7:0] recWb[4];
  logic [31:0] gotData;
  logic gotAbort;

  always #4 clk = ~clk;

  lpc_mem_host u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqReady(reqReady), .rspValid(rspValid),
    .rspAbort(rspAbort), .rspRdata(rspRdata), .ladOut(ladOut), .ladOe(ladOe),
    .ladIn(ladIn), .lfrmN(lfrmN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Target model: decodes a frame, then answers junk/short/long/junk/ready/data.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && !lfrmN && ladOe && ladOut != 4'hF) begin
        automatic logic [3:0] nb[16];
        automatic int n = 0;
        automatic logic [3:0] st = ladOut;
        automatic bit rd, isFw, go;
        automatic logic [31:0] a;
        automatic int k = 0, total;
        @(negedge clk);
        while (ladOe && n < 16) begin
          if (!lfrmN) frameErr++;
          nb[n] = ladOut; n++;
          @(negedge clk);
        end
        isFw = (st == 4'hD) || (st == 4'hE);
        rd   = (st == 4'hD) || (!isFw && nb[0] == 4'h4);
        if (isFw) a = {4'h0, nb[1], nb[2], nb[3], nb[4], nb[5], nb[6], nb[7]};
        else      a = {nb[1], nb[2], nb[3], nb[4], nb[5], nb[6], nb[7], nb[8]};
        if (recN < 4) begin
          recStart[recN] = st; recHdr0[recN] = nb[0]; recHdr8[recN] = nb[8];
          recAddr[recN] = a; recTar[recN] = nb[n-1];
          recWb[recN] = (n >= 12) ? {nb[10], nb[9]} : 8'h00;
        end
        recN++;
        total = nJunk + nShort + nLong + nJunk2 + (noReady ? 0 : (rd ? 3 : 1));
        go = 1;
        while (go) begin
          @(negedge clk);
          if (!lfrmN) begin ladIn = 4'hF; go = 0; end
          else begin
            automatic int j = k;
            automatic logic [7:0] d = a[7:0] ^ 8'hA5;
            if (ladOe) contention++;
            if (k >= total) begin ladIn = 4'hF; go = 0; end
            else if (j < nJunk) ladIn = junkNib;
            else if ((j -= nJunk) < nShort) ladIn = 4'h5;
            else if ((j -= nShort) < nLong) ladIn = 4'h6;
            else if ((j -= nLong) < nJunk2) ladIn = junkNib;
            else begin
              j -= nJunk2;
              ladIn = (j == 0) ? 4'h0 : (j == 1) ? d[3:0] : d[7:4];
            end
            k++;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && !lfrmN && ladOe && ladOut == 4'hF) abortRun++;
      else if (abortRun > 0) begin abortLen = abortRun; abortRun = 0; end
    end
  end

  task automatic setResp(input int j1, input int s, input int l, input int j2,
                         input logic [3:0] jn, input bit nr);
    nJunk = j1; nShort = s; nLong = l; nJunk2 = j2; junkNib = jn; noReady = nr;
  endtask

  task automatic doReq(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd);
    int t;
    recN = 0; frameErr = 0; contention = 0; abortLen = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!rspValid && t < 3000) begin @(negedge clk); t++; end
    gotData = rspRdata; gotAbort = rspAbort;
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R13 reset lfrmN", 32'(lfrmN), 32'd1);
    chk("R13 reset ladOe", 32'(ladOe), 32'd0);
    chk("R13 reset reqReady", 32'(reqReady), 32'd1);
    chk("R13 reset rspValid", 32'(rspValid), 32'd0);
  endtask

  task automatic tStdRead4();
    logic [31:0] b = 32'h00AB_CDE0, e;
    setResp(0, 2, 0, 0, 4'hF, 0);
    doReq(0, b, 2'd2, 0);
    chk("R5 byte transfers", 32'(recN), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 start std", 32'(recStart[i]), 32'h0);
      chk("R3 dir read", 32'(recHdr0[i]), 32'h4);
      chk("R5 addr incr", recAddr[i], b + 32'(i));
      chk("R7 tar ones", 32'(recTar[i]), 32'hF);
    end
    e = 0;
    for (int i = 0; i < 4; i++) e[8*i +: 8] = (b[7:0] + 8'(i)) ^ 8'hA5;
    chk("R6 R5 read merge", gotData, e);
    chk("R8 short wait no abort", 32'(gotAbort), 32'd0);
    chk("R7 no contention", 32'(contention), 32'd0);
    chk("R4 single start clk", 32'(frameErr), 32'd0);
  endtask

  task automatic tStdWrite2();
    setResp(0, 0, 3, 0, 4'hF, 0);
    doReq(1, 32'h0000_0FFF, 2'd1, 32'hDEAD_1234);
    chk("R5 write transfers", 32'(recN), 32'd2);
    chk("R3 dir write", 32'(recHdr0[0]), 32'h6);
    chk("R5 addr carry", recAddr[1], 32'h0000_1000);
    chk("R6 wbyte0 lo first", 32'(recWb[0]), 32'h34);
    chk("R6 wbyte1", 32'(recWb[1]), 32'h12);
    chk("R8 long wait ok", 32'(gotAbort), 32'd0);
  endtask

  task automatic tTpm();
    setResp(0, 0, 0, 0, 4'hF, 0);
    doReq(0, 32'hFED4_0FFF, 2'd0, 0);
    chk("R1 tpm start", 32'(recStart[0]), 32'h5);
    chk("R1 tpm addr", recAddr[0], 32'hFED4_0FFF);
    chk("R1 tpm data", gotData, 32'h0000_005A);
    doReq(1, 32'hFED4_1000, 2'd0, 32'h77);
    chk("R1 outside window std", 32'(recStart[0]), 32'h0);
  endtask

  task automatic tFw();
    setResp(0, 1, 1, 0, 4'hF, 0);
    doReq(0, 32'hFFFF_0010, 2'd1, 0);
    chk("R2 fw read start", 32'(recStart[0]), 32'hD);
    chk("R2 idsel", 32'(recHdr0[0]), 32'h0);
    chk("R2 msize", 32'(recHdr8[1]), 32'h0);
    chk("R2 addr28", recAddr[1], 32'h0FFF_0011);
    chk("R2 fw data", gotData, 32'h0000_B4B5);
    doReq(1, 32'hFF80_0000, 2'd0, 32'h5A);
    chk("R2 fw write start", 32'(recStart[0]), 32'hE);
    chk("R2 fw wbyte", 32'(recWb[0]), 32'h5A);
  endtask

  task automatic tWaitLimit();
    setResp(0, 5, 10, 0, 4'hF, 0);
    doReq(0, 32'h0000_2000, 2'd0, 0);
    chk("R8 15 waits ok", 32'(gotAbort), 32'd0);
    setResp(0, 6, 10, 0, 4'hF, 0);
    doReq(0, 32'h0000_2000, 2'd0, 0);
    chk("R8 16 waits abort", 32'(gotAbort), 32'd1);
    chk("R12 abort ones", gotData, 32'hFFFF_FFFF);
    chk("R12 abort length", 32'(abortLen), 32'd4);
  endtask

  task automatic tNoSync();
    setResp(3, 0, 0, 0, 4'hF, 0);
    doReq(0, 32'h0000_3000, 2'd0, 0);
    chk("R9 3 idle ok", 32'(gotAbort), 32'd0);
    setResp(3, 1, 0, 3, 4'hF, 0);
    doReq(0, 32'h0000_3000, 2'd0, 0);
    chk("R9 wait resets count", 32'(gotAbort), 32'd0);
    setResp(4, 0, 0, 0, 4'hF, 0);
    doReq(0, 32'h0000_3000, 2'd0, 0);
    chk("R9 4 idle abort", 32'(gotAbort), 32'd1);
  endtask

  task automatic tErrSync();
    setResp(3, 0, 0, 0, 4'hA, 0);
    doReq(0, 32'hFF00_0040, 2'd0, 0);
    chk("R10 fw err ignored", 32'(gotAbort), 32'd0);
    chk("R10 fw data", gotData, 32'h0000_00E5);
    setResp(4, 0, 0, 0, 4'hA, 0);
    doReq(0, 32'hFF00_0040, 2'd0, 0);
    chk("R10 fw err timeout", 32'(gotAbort), 32'd1);
    setResp(1, 0, 0, 0, 4'hA, 0);
    doReq(0, 32'h0000_0040, 2'd0, 0);
    chk("R11 std err abort", 32'(gotAbort), 32'd1);
  endtask

  task automatic tSilentMulti();
    setResp(100, 0, 0, 0, 4'hF, 1);
    doReq(0, 32'h0010_0000, 2'd2, 0);
    chk("R12 bytes skipped", 32'(recN), 32'd1);
    chk("R12 abort flag", 32'(gotAbort), 32'd1);
    chk("R12 all ones", gotData, 32'hFFFF_FFFF);
    chk("R12 abort len", 32'(abortLen), 32'd4);
    chk("R13 idle after", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tStdRead4();
    tStdWrite2();
    tTpm();
    tFw();
    tWaitLimit();
    tNoSync();
    tErrSync();
    tSilentMulti();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule